// File: doc/BRIEF.md
# Slow Clock Calibration Counter

This block measures how fast a low-frequency clock runs compared with the fast reference crystal clock that clocks the block itself. One of four candidate slow clocks is picked by a 2-bit selector. The block waits for the first rising edge of that clock. It then counts reference cycles over a programmed number of slow-clock periods and returns the mean number of reference cycles per slow period. The result is an unsigned fixed-point value with 19 fractional bits in a 32-bit word (13 integer bits). The reference crystal is expected to run at 32 MHz or 40 MHz, so typical results for slow clocks in the tens or hundreds of kilohertz sit well inside the integer range.

A measurement is started by a one-cycle start pulse. The selector and the cycle count are captured at that moment. The interface is plain control and status pins with no back-pressure: start is only taken while the block is idle, done is a single-cycle pulse, and the result and timeout flag stay on their pins until the next accepted start. A dead or very slow clock cannot hang the block. A hardware limit, scaled from the requested cycle count by a source-dependent shift, ends the run with the timeout flag set and a zero result.

Top module: `slowcal_top`

## Requirements
- R1: While reset is held and after its release, busy_o, done_o and timeout_o are 0 and ratio_o is 0.
- R2: start_i is taken only while busy_o is 0. With a non-zero cycle count, busy_o is 1 in the cycle after the accepting edge. A start pulse while busy_o is 1 has no effect on the running measurement or its result.
- R3: src_sel_i picks the measured clock: 0 selects slow_clk_mux_i, 1 selects slow_clk_rcd256_i, 2 selects slow_clk_x32k_i and 3 selects slow_clk_rc150k_i.
- R4: Each slow clock passes through a two-flop synchronizer and a rising-edge detector. The window opens at the first detected rising edge after start. It closes at the N-th detected rising edge after that, where N is the captured cycle count. ratio_o = floor(R * 2^19 / N), where R is the number of reference cycles between the opening and closing edges.
- R5: The timeout limit in reference cycles is N shifted left by 12 for sources 0, 1 and 2, and N shifted left by 10 for source 3. It is counted from the accepting edge. When the count reaches the limit before the window closes, the run ends with timeout_o = 1 and ratio_o = 0, between limit and limit+4 cycles after start.
- R6: A start with a cycle count of 0 completes in the cycle after the accepting edge: done_o = 1, ratio_o = 0, timeout_o = 0, and busy_o stays 0.
- R7: done_o is high for exactly one cycle and busy_o is 0 in that cycle. ratio_o and timeout_o keep their values until the next accepted start.
- R8: src_sel_i and cycles_i are captured when start is accepted. Changing them during a measurement has no effect on that measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference crystal clock; all logic runs on it |
| rst_n | input | 1 | Active-low reset, synchronous to clk_ref |
| slow_clk_mux_i | input | 1 | Slow clock currently chosen by the system (source 0) |
| slow_clk_rcd256_i | input | 1 | Fast RC oscillator divided by 256 (source 1) |
| slow_clk_x32k_i | input | 1 | External 32 kHz crystal (source 2) |
| slow_clk_rc150k_i | input | 1 | Internal ~150 kHz oscillator (source 3) |
| src_sel_i | input | 2 | Source selector, sampled at start |
| cycles_i | input | CNT_W | Number of slow periods to average, sampled at start |
| start_i | input | 1 | One-cycle start request |
| busy_o | output | 1 | Measurement or division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Last run ended on the timeout limit |
| ratio_o | output | RATIO_W | Reference cycles per slow period, 19 fractional bits |

## Verification
The bench uses slow clocks whose period alternates between two lengths. Results then carry real fractional bits, and over an even window the exact sum is known; a divider that dropped the 19-bit scaling or lost a quotient bit would give a value off by a power of two or by a low-order bit. Each run gives every source a different period, so a swapped selector decode shows up as a wrong ratio. Dead and far-too-slow clocks are run on every timeout shift. A design with the wrong shift would end too early or too late against the expected latency, and one that kept the previous result would show a stale non-zero ratio. A zero count, a second start issued mid-run, and selector and count pins changed mid-run check that nothing uncaptured leaks into the result.

// File: rtl/slowcal_pkg.sv
package slowcal_pkg;

  typedef enum logic [1:0] {
    SRC_MUXED    = 2'd0,
    SRC_RC_DIV   = 2'd1,
    SRC_XTAL_32K = 2'd2,
    SRC_RC_150K  = 2'd3
  } slow_src_e;

  localparam int unsigned NUM_SRC         = 4;
  localparam int unsigned TMO_SHIFT_LONG  = 12;
  localparam int unsigned TMO_SHIFT_SHORT = 10;

  typedef enum logic [1:0] {
    CTL_IDLE,
    CTL_MEAS,
    CTL_DIV
  } ctl_state_e;

  typedef enum logic [1:0] {
    WIN_IDLE,
    WIN_ALIGN,
    WIN_COUNT
  } win_state_e;

  // Shift applied to the slow-cycle count to form the timeout limit.
  function automatic int unsigned tmo_shift(input logic [1:0] sel);
    return (sel == SRC_RC_150K) ? TMO_SHIFT_SHORT : TMO_SHIFT_LONG;
  endfunction

endpackage

// File: rtl/slowcal_edge_sync.sv
module slowcal_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R4

endmodule

// File: rtl/slowcal_window.sv
module slowcal_window
  import slowcal_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int REF_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] cycles_i,
  input  logic [REF_W-1:0] limit_i,
  input  logic             edge_i,
  output logic             done_o,
  output logic             expired_o,
  output logic [REF_W-1:0] ref_cnt_o
);

  win_state_e       state_q;
  logic [CNT_W-1:0] n_q;
  logic [CNT_W-1:0] edges_q;
  logic [REF_W-1:0] lim_q;
  logic [REF_W-1:0] tmo_q;
  logic [REF_W-1:0] ref_q;
  logic             last_edge;
  logic             at_limit;

  assign last_edge = edge_i && ((edges_q + CNT_W'(1)) == n_q);
  assign at_limit  = (tmo_q == lim_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= WIN_IDLE;
      n_q       <= '0;
      edges_q   <= '0;
      lim_q     <= '0;
      tmo_q     <= '0;
      ref_q     <= '0;
      done_o    <= 1'b0;
      expired_o <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      expired_o <= 1'b0;
      case (state_q)
        WIN_IDLE: begin
          if (arm_i) begin
            state_q <= WIN_ALIGN;
            n_q     <= cycles_i;
            lim_q   <= limit_i;
            tmo_q   <= '0;
          end
        end
        WIN_ALIGN: begin
          tmo_q <= tmo_q + REF_W'(1);
          if (at_limit) begin
            expired_o <= 1'b1;
            state_q   <= WIN_IDLE;
          end else if (edge_i) begin
            state_q <= WIN_COUNT;
            ref_q   <= '0;
            edges_q <= '0;
          end
        end
        WIN_COUNT: begin
          tmo_q <= tmo_q + REF_W'(1);
          ref_q <= ref_q + REF_W'(1);
          if (last_edge) begin
            done_o  <= 1'b1;
            state_q <= WIN_IDLE;
          end else if (at_limit) begin
            expired_o <= 1'b1;
            state_q   <= WIN_IDLE;
          end else if (edge_i) begin
            edges_q <= edges_q + CNT_W'(1);
          end
        end
        default: state_q <= WIN_IDLE;
      endcase
    end
  end

  assign ref_cnt_o = ref_q;

  AST_WIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != WIN_IDLE) |-> (tmo_q <= lim_q)); // R5
  AST_WIN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && expired_o)); // R5
  AST_WIN_REF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WIN_COUNT) |-> (ref_q < tmo_q)); // R4

endmodule

// File: rtl/slowcal_divider.sv
module slowcal_divider #(
  parameter int NUM_W = 47,
  parameter int DEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             valid_o,
  output logic [NUM_W-1:0] quo_o
);

  localparam int IT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] q_q;
  logic [DEN_W-1:0] rem_q;
  logic [IT_W-1:0]  it_q;
  logic             run_q;
  logic [DEN_W:0]   rem_sh;
  logic             fits;
  logic [DEN_W-1:0] rem_next;

  always_comb begin
    rem_sh   = {rem_q, q_q[NUM_W-1]};
    fits     = (rem_sh >= {1'b0, den_i});
    rem_next = fits ? DEN_W'(rem_sh - {1'b0, den_i}) : rem_sh[DEN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_q     <= '0;
      rem_q   <= '0;
      it_q    <= '0;
      run_q   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (start_i) begin
        q_q   <= num_i;
        rem_q <= '0;
        it_q  <= IT_W'(NUM_W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= rem_next;
        q_q   <= {q_q[NUM_W-2:0], fits};
        it_q  <= it_q - IT_W'(1);
        if (it_q == IT_W'(1)) begin
          run_q   <= 1'b0;
          valid_o <= 1'b1;
        end
      end
    end
  end

  assign quo_o = q_q;

  AST_DIV_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R7
  AST_DIV_REM_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (rem_q < den_i)); // R4

endmodule

// File: rtl/slowcal_top.sv
module slowcal_top
  import slowcal_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int RATIO_W     = 32,
  parameter int FRAC_W      = 19,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_ref,
  input  logic               rst_n,
  input  logic               slow_clk_mux_i,
  input  logic               slow_clk_rcd256_i,
  input  logic               slow_clk_x32k_i,
  input  logic               slow_clk_rc150k_i,
  input  logic [1:0]         src_sel_i,
  input  logic [CNT_W-1:0]   cycles_i,
  input  logic               start_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               timeout_o,
  output logic [RATIO_W-1:0] ratio_o
);

  localparam int REF_W  = CNT_W + TMO_SHIFT_LONG;
  localparam int DIVN_W = REF_W + FRAC_W;

  logic [NUM_SRC-1:0] slow_vec;
  logic [NUM_SRC-1:0] rise_vec;
  logic               sel_edge;

  ctl_state_e         state_q;
  logic [1:0]         sel_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               arm;
  logic [REF_W-1:0]   limit_w;
  logic               win_done;
  logic               win_expired;
  logic [REF_W-1:0]   win_ref;
  logic               div_valid;
  logic [DIVN_W-1:0]  div_quo;
  logic               quo_ovf;

  assign slow_vec = {slow_clk_rc150k_i, slow_clk_x32k_i, slow_clk_rcd256_i, slow_clk_mux_i};

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_sync
    slowcal_edge_sync #(
      .STAGES (SYNC_STAGES)
    ) u_sync (
      .clk     (clk_ref),
      .rst_n   (rst_n),
      .async_i (slow_vec[gi]),
      .rise_o  (rise_vec[gi])
    );
  end

  assign sel_edge = rise_vec[sel_q];
  assign arm      = (state_q == CTL_IDLE) && start_i && (cycles_i != '0);
  assign limit_w  = REF_W'(cycles_i) << tmo_shift(src_sel_i);

  slowcal_window #(
    .CNT_W (CNT_W),
    .REF_W (REF_W)
  ) u_window (
    .clk       (clk_ref),
    .rst_n     (rst_n),
    .arm_i     (arm),
    .cycles_i  (cycles_i),
    .limit_i   (limit_w),
    .edge_i    (sel_edge),
    .done_o    (win_done),
    .expired_o (win_expired),
    .ref_cnt_o (win_ref)
  );

  slowcal_divider #(
    .NUM_W (DIVN_W),
    .DEN_W (CNT_W)
  ) u_divider (
    .clk     (clk_ref),
    .rst_n   (rst_n),
    .start_i (win_done),
    .num_i   ({win_ref, {FRAC_W{1'b0}}}),
    .den_i   (cnt_q),
    .valid_o (div_valid),
    .quo_o   (div_quo)
  );

  assign quo_ovf = |div_quo[DIVN_W-1:RATIO_W];

  always_ff @(posedge clk_ref) begin
    if (!rst_n) begin
      state_q   <= CTL_IDLE;
      sel_q     <= '0;
      cnt_q     <= '0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      ratio_o   <= '0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        CTL_IDLE: begin
          if (start_i) begin
            sel_q     <= src_sel_i;
            cnt_q     <= cycles_i;
            timeout_o <= 1'b0;
            ratio_o   <= '0;
            if (cycles_i == '0) done_o  <= 1'b1;
            else                state_q <= CTL_MEAS;
          end
        end
        CTL_MEAS: begin
          if (win_done) begin
            state_q <= CTL_DIV;
          end else if (win_expired) begin
            timeout_o <= 1'b1;
            done_o    <= 1'b1;
            state_q   <= CTL_IDLE;
          end
        end
        CTL_DIV: begin
          if (div_valid) begin
            ratio_o <= quo_ovf ? {RATIO_W{1'b1}} : div_quo[RATIO_W-1:0];
            done_o  <= 1'b1;
            state_q <= CTL_IDLE;
          end
        end
        default: state_q <= CTL_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != CTL_IDLE);

  AST_DONE_NOT_BUSY: assert property (@(posedge clk_ref) disable iff (!rst_n)
    done_o |-> !busy_o); // R7
  AST_TIMEOUT_ZERO: assert property (@(posedge clk_ref) disable iff (!rst_n)
    timeout_o |-> (ratio_o == '0)); // R5
  AST_ZERO_COUNT: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!busy_o && start_i && (cycles_i == '0)) |=> (done_o && !timeout_o && !busy_o)); // R6
  AST_CFG_HELD: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(sel_q) && $stable(cnt_q))); // R8
  AST_QUO_FITS: assert property (@(posedge clk_ref) disable iff (!rst_n)
    div_valid |-> !quo_ovf); // R4

endmodule

// File: tb/slowcal_top_tb_top.sv
`timescale 1ns/1ps
module slowcal_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  sclk = 4'b0;
  logic [1:0]  src_sel = 2'd0;
  logic [15:0] cycles = 16'd0;
  logic        start = 1'b0;
  logic        busy, done, timeout;
  logic [31:0] ratio;

  int hi_len [4];
  int lo_a   [4];
  int lo_b   [4];
  int gcnt   [4];
  bit use_b  [4];

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  slowcal_top dut_i (
    .clk_ref           (clk),
    .rst_n             (rst_n),
    .slow_clk_mux_i    (sclk[0]),
    .slow_clk_rcd256_i (sclk[1]),
    .slow_clk_x32k_i   (sclk[2]),
    .slow_clk_rc150k_i (sclk[3]),
    .src_sel_i         (src_sel),
    .cycles_i          (cycles),
    .start_i           (start),
    .busy_o            (busy),
    .done_o            (done),
    .timeout_o         (timeout),
    .ratio_o           (ratio)
  );

  // Slow clock generators: high for hi_len, low alternating lo_a / lo_b.
  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (hi_len[i] == 0) begin
        sclk[i] = 1'b0;
        gcnt[i] = 0;
      end else begin
        gcnt[i] = gcnt[i] + 1;
        if (sclk[i] && gcnt[i] >= hi_len[i]) begin
          sclk[i] = 1'b0;
          gcnt[i] = 0;
        end else if (!sclk[i] && gcnt[i] >= (use_b[i] ? lo_b[i] : lo_a[i])) begin
          sclk[i]  = 1'b1;
          gcnt[i]  = 0;
          use_b[i] = !use_b[i];
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !finished) begin
      finished = 1'b1;
      tests = tests + 1;
      fails = fails + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<190000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint exp_ratio(input int n, input int hi, input int la, input int lb);
    longint tot;
    if (n % 2 == 0) tot = longint'(n / 2) * longint'(2 * hi + la + lb);
    else            tot = longint'(n) * longint'(hi + la);
    return (tot << 19) / n;
  endfunction

  function automatic longint limit_of(input int sel, input int n);
    return (sel == 3) ? (longint'(n) << 10) : (longint'(n) << 12);
  endfunction

  task automatic set_clk(input int i, input int hi, input int la, input int lb);
    hi_len[i] = hi;
    lo_a[i]   = la;
    lo_b[i]   = lb;
  endtask

  task automatic settle();
    repeat (120) @(negedge clk);
  endtask

  task automatic run_meas(input int sel, input int n, input bit exp_tmo,
                          input longint exp_r, input bit disturb, input string req);
    int c;
    @(negedge clk);
    src_sel = sel[1:0];
    cycles  = n[15:0];
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    c = 1;
    if (n != 0) chk(busy == 1'b1, "R2", "busy after start", longint'(busy), 1);
    if (disturb) begin
      // R2 / R8: second start and changed pins while busy must not matter
      src_sel = 2'(sel + 1);
      cycles  = 16'(n + 5);
      start   = 1'b1;
      @(negedge clk);
      start = 1'b0;
      c++;
    end
    while (!done && c < 20000) begin
      @(negedge clk);
      c++;
    end
    chk(done == 1'b1, req, "done seen", longint'(done), 1);
    chk(timeout == exp_tmo, exp_tmo ? "R5" : req, "timeout flag", longint'(timeout), longint'(exp_tmo));
    chk(longint'(ratio) == exp_r, exp_tmo ? "R5" : req, "ratio", longint'(ratio), exp_r);
    chk(busy == 1'b0, "R7", "busy low with done", longint'(busy), 0);
    if (exp_tmo) begin
      longint lim = limit_of(sel, n);
      chk(c >= lim && c <= lim + 4, "R5", "timeout latency", c, lim);
    end
    if (n == 0) chk(c == 1, "R6", "zero count latency", c, 1);
    @(negedge clk);
    chk(done == 1'b0, "R7", "done single cycle", longint'(done), 0);
    chk(longint'(ratio) == exp_r, "R7", "ratio held", longint'(ratio), exp_r);
    chk(timeout == exp_tmo, "R7", "timeout held", longint'(timeout), longint'(exp_tmo));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) begin
      set_clk(i, 4, 4, 4);
      gcnt[i]  = 0;
      use_b[i] = 1'b0;
    end
    repeat (5) @(negedge clk);
    // R1: values during reset
    chk(busy == 0 && done == 0 && timeout == 0, "R1", "flags in reset",
        longint'({busy, done, timeout}), 0);
    chk(ratio == 0, "R1", "ratio in reset", longint'(ratio), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && timeout == 0, "R1", "flags after reset",
        longint'({busy, done, timeout}), 0);

    // R6: zero slow-cycle count
    run_meas(2, 0, 1'b0, 0, 1'b0, "R6");

    // R3: distinct periods per source, each measured by its code
    set_clk(0, 3, 4, 4);
    set_clk(1, 5, 6, 6);
    set_clk(2, 8, 9, 9);
    set_clk(3, 2, 3, 3);
    settle();
    run_meas(0, 4, 1'b0, exp_ratio(4, 3, 4, 4), 1'b0, "R3");
    run_meas(1, 4, 1'b0, exp_ratio(4, 5, 6, 6), 1'b0, "R3");
    run_meas(2, 4, 1'b0, exp_ratio(4, 8, 9, 9), 1'b0, "R3");
    run_meas(3, 4, 1'b0, exp_ratio(4, 2, 3, 3), 1'b0, "R3");

    // R4: fractional result from alternating periods, and a single-cycle window
    set_clk(1, 3, 3, 4);
    settle();
    run_meas(1, 2, 1'b0, exp_ratio(2, 3, 3, 4), 1'b0, "R4");
    run_meas(3, 1, 1'b0, exp_ratio(1, 2, 3, 3), 1'b0, "R4");
    set_clk(2, 2, 5, 2);
    settle();
    run_meas(2, 200, 1'b0, exp_ratio(200, 2, 5, 2), 1'b0, "R4");

    // R8 / R2: pins changed and start re-issued mid-run
    run_meas(0, 6, 1'b0, exp_ratio(6, 3, 4, 4), 1'b1, "R8");

    // R5: dead clocks on every shift, after a non-zero result
    set_clk(2, 0, 0, 0);
    settle();
    run_meas(2, 3, 1'b1, 0, 1'b0, "R5");
    run_meas(0, 6, 1'b0, exp_ratio(6, 3, 4, 4), 1'b0, "R4");
    set_clk(3, 0, 0, 0);
    settle();
    run_meas(3, 4, 1'b1, 0, 1'b0, "R5");
    set_clk(1, 0, 0, 0);
    settle();
    run_meas(1, 2, 1'b1, 0, 1'b0, "R5");
    // R5: clocks far too slow for the limit
    set_clk(0, 3000, 3000, 3000);
    settle();
    run_meas(0, 1, 1'b1, 0, 1'b0, "R5");
    set_clk(3, 1500, 1500, 1500);
    settle();
    run_meas(3, 2, 1'b1, 0, 1'b0, "R5");

    // Random trials over all sources (R3, R4)
    for (int t = 0; t < 30; t++) begin
      int hs [4];
      int as [4];
      int bs [4];
      int sel;
      int n;
      for (int i = 0; i < 4; i++) begin
        hs[i] = 2 + int'($urandom % 15);
        as[i] = 2 + int'($urandom % 15);
        bs[i] = ($urandom % 2 == 1) ? 2 + int'($urandom % 15) : as[i];
        set_clk(i, hs[i], as[i], bs[i]);
      end
      sel = int'($urandom % 4);
      n   = 1 + int'($urandom % 24);
      if (as[sel] != bs[sel] && (n % 2 == 1)) n++;
      settle();
      run_meas(sel, n, 1'b0, exp_ratio(n, hs[sel], as[sel], bs[sel]), (t % 5) == 0, "R4");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule